// File: doc/BRIEF.md
# Sequence-Checked Watchdog Kick Gate

This block sits between software and the service input of a watchdog timer. Software marks each loop iteration with two strobes. An advance strobe at the top of the loop moves a running state token forward by a fixed step. A validate strobe at the bottom of the loop moves an expected-value register forward by the same step, then compares the two. When they agree, the gate passes a single one-cycle kick to the watchdog.

When the token and the expected value disagree, the kick is withheld and a sticky error flag rises. The watchdog is then left to expire and reset the system. Code that wanders into the validate path without having passed through the advance path cannot service the watchdog. Neither can code that runs the loop out of order.

Top module: `seq_kick_gate`

## Requirements
- R1: A synchronous reset clears both 16-bit registers to zero and drives `kick_o` and `err_o` low. After reset, one advance followed by one validate produces a kick.
- R2: A validate that follows exactly one advance, with no error pending, raises `kick_o` in the cycle after the validate strobe. The pulse lasts exactly one clock cycle.
- R3: A validate with no preceding advance since reset produces no kick and sets `err_o`.
- R4: Two validates with only one advance before them produce a kick for the first validate. The second validate produces no kick and sets `err_o`.
- R5: Two advances followed by one validate produce no kick and set `err_o`.
- R6: An advance and a validate in the same cycle are a sequence error. They produce no kick and set `err_o`.
- R7: Once `err_o` is set, it stays high and every later validate is refused until reset.
- R8: The token and the expected value step by 16'h1111 and wrap modulo 2^16. Correct advance/validate pairs keep producing kicks across the wrap point, which is reached after 16 pairs.
- R9: An advance alone never produces a kick. `kick_o` rises only in the cycle right after a validate strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Advance strobe, one cycle per loop start |
| val_i | input | 1 | Validate strobe, one cycle per loop end |
| kick_o | output | 1 | One-cycle service pulse to the watchdog |
| err_o | output | 1 | Sticky sequence-error flag |

## Verification
The correct pattern runs advance and then validate, repeated for more than 16 rounds so that both registers wrap. This pattern separates a true step-and-compare design from one that only counts strobes. The faulty patterns are:
- validate first;
- validate twice;
- advance twice;
- both strobes in one cycle.

Each faulty pattern isolates one ordering fault and shows that it withholds the kick and raises the error. A correct sequence after an error shows that the flag is sticky and still blocks the kick. The same sequence after a reset shows that the reset restores normal service.

// File: rtl/seq_kick_gate.sv
module seq_kick_gate #(
  parameter int unsigned   W    = 16,
  parameter logic [W-1:0]  STEP = 'h1111
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  input  logic val_i,
  output logic kick_o,
  output logic err_o
);

  logic [W-1:0] tok_q, exp_q;
  logic         kick_q, err_q;

  wire [W-1:0] exp_nx   = exp_q + STEP;
  wire         val_only = val_i & ~adv_i;
  wire         match    = (tok_q == exp_nx);
  wire         kick_d   = val_only & match & ~err_q;
  wire         bad      = (val_i & adv_i) | (val_only & ~match);

  always_ff @(posedge clk) begin
    if (rst) begin
      tok_q  <= '0;
      exp_q  <= '0;
      kick_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (adv_i) tok_q <= tok_q + STEP;
      if (val_i) exp_q <= exp_nx;
      kick_q <= kick_d;
      err_q  <= err_q | bad;
    end
  end

  assign kick_o = kick_q;
  assign err_o  = err_q;

endmodule

module seq_kick_gate_chk (
  input logic clk,
  input logic rst,
  input logic adv_i,
  input logic val_i,
  input logic kick_o,
  input logic err_o
);

  assert_kick_one_wide_R2: assert property (@(posedge clk) disable iff (rst)
    kick_o |=> !kick_o);

  assert_kick_after_validate_R9: assert property (@(posedge clk) disable iff (rst)
    kick_o |-> ($past(val_i) && !$past(adv_i)));

  assert_same_cycle_error_R6: assert property (@(posedge clk) disable iff (rst)
    (adv_i && val_i) |=> (err_o && !kick_o));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  assert_no_kick_in_error_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !kick_o);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!kick_o && !err_o));

endmodule

bind seq_kick_gate seq_kick_gate_chk i_chk (
  .clk(clk), .rst(rst), .adv_i(adv_i), .val_i(val_i),
  .kick_o(kick_o), .err_o(err_o)
);

// File: tb/test_seq_kick_gate.sv
module test_seq_kick_gate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b0;
  logic val = 1'b0;
  logic kick, err;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  seq_kick_gate i_seq_kick_gate (
    .clk(clk), .rst(rst), .adv_i(adv), .val_i(val),
    .kick_o(kick), .err_o(err)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic v);
    @(negedge clk);
    adv = a;
    val = v;
    @(negedge clk);
    adv = 1'b0;
    val = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1", "kick after reset", kick, 1'b0);
    check("R1", "err after reset", err, 1'b0);
  endtask

  task automatic t_basic();
    do_reset();
    step(1, 0);
    check("R9", "kick after lone advance", kick, 1'b0);
    step(0, 1);
    check("R2", "kick after validate", kick, 1'b1);
    check("R2", "err after good pair", err, 1'b0);
    step(0, 0);
    check("R2", "kick one cycle wide", kick, 1'b0);
  endtask

  task automatic t_wrap();
    do_reset();
    for (int i = 0; i < 20; i++) begin
      step(1, 0);
      check("R9", "no kick on advance", kick, 1'b0);
      step(0, 1);
      check("R8", "kick across wrap", kick, 1'b1);
    end
    check("R8", "no error across wrap", err, 1'b0);
  endtask

  task automatic t_val_first();
    do_reset();
    step(0, 1);
    check("R3", "kick on bare validate", kick, 1'b0);
    check("R3", "err on bare validate", err, 1'b1);
  endtask

  task automatic t_double_val();
    do_reset();
    step(1, 0);
    step(0, 1);
    check("R4", "first validate kicks", kick, 1'b1);
    step(0, 1);
    check("R4", "second validate no kick", kick, 1'b0);
    check("R4", "second validate err", err, 1'b1);
  endtask

  task automatic t_double_adv();
    do_reset();
    step(1, 0);
    step(1, 0);
    step(0, 1);
    check("R5", "kick after two advances", kick, 1'b0);
    check("R5", "err after two advances", err, 1'b1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    step(1, 1);
    check("R6", "kick on joint strobes", kick, 1'b0);
    check("R6", "err on joint strobes", err, 1'b1);
  endtask

  task automatic t_sticky();
    do_reset();
    step(0, 1);
    for (int i = 0; i < 3; i++) begin
      step(1, 0);
      step(0, 1);
      check("R7", "kick blocked while err", kick, 1'b0);
      check("R7", "err stays set", err, 1'b1);
    end
    do_reset();
    step(1, 0);
    step(0, 1);
    check("R1", "kick restored after reset", kick, 1'b1);
    check("R1", "err clear after reset", err, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_basic();
    t_wrap();
    t_val_first();
    t_double_val();
    t_double_adv();
    t_same_cycle();
    t_sticky();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule